// File: doc/BRIEF.md
# Overlapping 101 Pattern Recognizer (Moore and Mealy pair)

This block watches a one-bit serial stream, sampled on every rising clock edge, and raises a flag each time the three most recent bits are 1, 0, 1 in that order. Occurrences may share bits, so a stream such as 10101 produces two hits. Two recognizers run in parallel from the same clock, reset and serial input.

The first is a four-state Moore machine. Its flag is decoded from the state register alone, so it appears one clock after the final 1 and holds steady for a whole period. The second is a three-state Mealy machine. Its flag combines the state with the live input, so it is visible during the cycle whose rising edge consumes the final 1, one clock ahead of the Moore flag. Both state vectors are brought out for observation.

A parameter chooses whether each machine's next-state logic is written as minimized sum-of-products equations or as a per-state case table. Both forms give the same behaviour.

Top module: `pat101_dual_recognizer`

## Requirements
- R1: While `rst` is high at a rising edge, both state outputs become 00 at that edge. Both flags read 0 for as long as `rst` is high, whatever the serial input is.
- R2: `hit_moore` is 1 exactly during the clock period that follows the rising edge which consumed the final 1 of a 1,0,1 run. It changes only at rising edges. For the stream 111101 it is high only in the period after the sixth bit.
- R3: Overlapping matches all count. For the stream 10101, both flags signal a hit for the third bit and again for the fifth bit. For the stream 110101100, both flags signal a hit for the fourth bit and again for the sixth bit.
- R4: `moore_state` uses these codes, bit 1 first. 00 means no progress. 01 means the last bit was 1 and did not complete a match. 10 means the last two bits were 1 then 0. 11 means the last three bits were 1, 0, 1. Its bit 0 always equals the bit taken at the previous edge.
- R5: `mealy_state` uses only three codes: 00 for no progress, 01 when the last bit was 1, and 10 when the last two bits were 1 then 0. Code 11 never appears after reset.
- R6: `hit_mealy` equals `din` AND (`mealy_state` == 10), evaluated combinationally within the current cycle. A change on `din` shows on the flag before the next edge.
- R7: Outside reset, the value of `hit_moore` in every cycle equals the value `hit_mealy` had just before the preceding rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial bit under test |
| hit_moore | output | 1 | Registered-state match flag, one clock after the final 1 |
| hit_mealy | output | 1 | Combinational match flag, valid while the final 1 is presented |
| moore_state | output | 2 | Moore state register (A in bit 1, B in bit 0) |
| mealy_state | output | 2 | Mealy state register (A in bit 1, B in bit 0) |

## Verification
The Mealy flag is due in the same cycle in which the final 1 is driven. The bench drives `din` at the falling edge and samples the flag one time unit later, well before the next rising edge. It also samples the flag just before each new drive, which shows that the flag follows the input and not just the state. Both state vectors and the Moore flag are due one rising edge after the bit that caused them. They are checked at the following falling edge against a three-bit history model in the bench, and the Moore flag is compared there with the Mealy value recorded half a period before that edge.

// File: rtl/pat101_pkg.sv
package pat101_pkg;
   localparam int unsigned REC_STATE_W = 2;

   typedef logic [REC_STATE_W-1:0] rec_state_t;

   localparam rec_state_t ST_EMPTY   = 2'b00;
   localparam rec_state_t ST_SAW1    = 2'b01;
   localparam rec_state_t ST_SAW10   = 2'b10;
   localparam rec_state_t ST_SAW101  = 2'b11;

   typedef enum logic [0:0] {
      NS_EQUATIONS = 1'b0,
      NS_TABLE     = 1'b1
   } ns_style_e;
endpackage

// File: rtl/pat101_moore_fsm.sv
module pat101_moore_fsm
   import pat101_pkg::*;
#(
   parameter int unsigned STATE_W  = REC_STATE_W,
   parameter ns_style_e   NS_STYLE = NS_EQUATIONS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               din,
   output logic [STATE_W-1:0] state_q,
   output logic               accept
);
   localparam int unsigned A_BIT = STATE_W - 1;
   localparam int unsigned B_BIT = 0;

   generate
      if (STATE_W != 2) begin : g_bad_width
         $error("pat101_moore_fsm: STATE_W must be 2");
      end
   endgenerate

   logic [STATE_W-1:0] state_d;

   generate
      if (NS_STYLE == NS_EQUATIONS) begin : g_ns_eqn
         always_comb begin
            state_d        = '0;
            state_d[A_BIT] = (~din & state_q[B_BIT]) |
                             (din & state_q[A_BIT] & ~state_q[B_BIT]);
            state_d[B_BIT] = din;
         end
      end else begin : g_ns_tbl
         always_comb begin
            unique case (state_q)
               ST_EMPTY:  state_d = din ? ST_SAW1   : ST_EMPTY;
               ST_SAW1:   state_d = din ? ST_SAW1   : ST_SAW10;
               ST_SAW10:  state_d = din ? ST_SAW101 : ST_EMPTY;
               ST_SAW101: state_d = din ? ST_SAW1   : ST_SAW10;
               default:   state_d = ST_EMPTY;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_EMPTY;
      end else begin
         state_q <= state_d;
      end
   end

   assign accept = state_q[A_BIT] & state_q[B_BIT];
endmodule

// File: rtl/pat101_mealy_fsm.sv
module pat101_mealy_fsm
   import pat101_pkg::*;
#(
   parameter int unsigned STATE_W  = REC_STATE_W,
   parameter ns_style_e   NS_STYLE = NS_EQUATIONS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               din,
   output logic [STATE_W-1:0] state_q,
   output logic               accept
);
   localparam int unsigned A_BIT = STATE_W - 1;
   localparam int unsigned B_BIT = 0;

   generate
      if (STATE_W != 2) begin : g_bad_width
         $error("pat101_mealy_fsm: STATE_W must be 2");
      end
   endgenerate

   logic [STATE_W-1:0] state_d;

   generate
      if (NS_STYLE == NS_EQUATIONS) begin : g_ns_eqn
         always_comb begin
            state_d        = '0;
            state_d[A_BIT] = ~din & state_q[B_BIT];
            state_d[B_BIT] = din;
         end
      end else begin : g_ns_tbl
         // code 11 is unused; its row follows the equations so it exits in one clock
         always_comb begin
            unique case (state_q)
               ST_EMPTY:  state_d = din ? ST_SAW1 : ST_EMPTY;
               ST_SAW1:   state_d = din ? ST_SAW1 : ST_SAW10;
               ST_SAW10:  state_d = din ? ST_SAW1 : ST_EMPTY;
               ST_SAW101: state_d = din ? ST_SAW1 : ST_SAW10;
               default:   state_d = ST_EMPTY;
            endcase
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_EMPTY;
      end else begin
         state_q <= state_d;
      end
   end

   assign accept = din & state_q[A_BIT];
endmodule

// File: rtl/pat101_dual_recognizer.sv
module pat101_dual_recognizer
   import pat101_pkg::*;
#(
   parameter int unsigned STATE_W  = REC_STATE_W,
   parameter ns_style_e   NS_STYLE = NS_EQUATIONS
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               din,
   output logic               hit_moore,
   output logic               hit_mealy,
   output logic [STATE_W-1:0] moore_state,
   output logic [STATE_W-1:0] mealy_state
);
   generate
      if (STATE_W != REC_STATE_W) begin : g_bad_width
         $error("pat101_dual_recognizer: STATE_W must equal REC_STATE_W");
      end
   endgenerate

   logic moore_acc;
   logic mealy_acc;

   pat101_moore_fsm #(
      .STATE_W  (STATE_W),
      .NS_STYLE (NS_STYLE)
   ) u_moore (
      .clk     (clk),
      .rst     (rst),
      .din     (din),
      .state_q (moore_state),
      .accept  (moore_acc)
   );

   pat101_mealy_fsm #(
      .STATE_W  (STATE_W),
      .NS_STYLE (NS_STYLE)
   ) u_mealy (
      .clk     (clk),
      .rst     (rst),
      .din     (din),
      .state_q (mealy_state),
      .accept  (mealy_acc)
   );

   // both flags held low while reset is applied
   assign hit_moore = moore_acc & ~rst;
   assign hit_mealy = mealy_acc & ~rst;
endmodule

// File: rtl/pat101_dual_recognizer_chk.sv
module pat101_dual_recognizer_chk #(
   parameter int unsigned STATE_W = 2
) (
   input logic               clk,
   input logic               rst,
   input logic               din,
   input logic               hit_moore,
   input logic               hit_mealy,
   input logic [STATE_W-1:0] moore_state,
   input logic [STATE_W-1:0] mealy_state
);
   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (moore_state == '0) && (mealy_state == '0)); // R1

   AST_RESET_QUIET: assert property (@(posedge clk)
      rst |-> !hit_moore && !hit_mealy); // R1

   AST_MOORE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(din) && $past(mealy_state) == 2'b10) |-> hit_moore); // R2

   AST_MOORE_LSB_TRACK: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> moore_state[0] == $past(din)); // R4

   AST_MEALY_LEGAL: assert property (@(posedge clk) disable iff (rst)
      mealy_state != 2'b11); // R5

   AST_MOORE_LAGS_MEALY: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> hit_moore == $past(hit_mealy)); // R7
endmodule

bind pat101_dual_recognizer pat101_dual_recognizer_chk #(
   .STATE_W (STATE_W)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .din         (din),
   .hit_moore   (hit_moore),
   .hit_mealy   (hit_mealy),
   .moore_state (moore_state),
   .mealy_state (mealy_state)
);

// File: tb/pat101_dual_recognizer_tb.sv
module pat101_dual_recognizer_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       din = 1'b0;
   logic       hit_moore;
   logic       hit_mealy;
   logic [1:0] moore_state;
   logic [1:0] mealy_state;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   // reference: bits taken since reset (zeros before)
   logic [2:0] hist       = 3'b000;
   logic       prev_mealy = 1'b0;
   logic       prev_exp   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pat101_dual_recognizer u_dut (
      .clk         (clk),
      .rst         (rst),
      .din         (din),
      .hit_moore   (hit_moore),
      .hit_mealy   (hit_mealy),
      .moore_state (moore_state),
      .mealy_state (mealy_state)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [1:0] exp_moore_st(input logic [2:0] h);
      if (h == 3'b101)     return 2'b11;
      if (h[0])            return 2'b01;
      if (h[1:0] == 2'b10) return 2'b10;
      return 2'b00;
   endfunction

   function automatic logic [1:0] exp_mealy_st(input logic [2:0] h);
      if (h[0])            return 2'b01;
      if (h[1:0] == 2'b10) return 2'b10;
      return 2'b00;
   endfunction

   // one serial bit: checks results of the previous edge, drives, checks the Mealy flag
   task automatic step(input logic b);
      logic exp_now;
      @(negedge clk);
      check(moore_state == exp_moore_st(hist), "R4 moore_state", moore_state, exp_moore_st(hist));
      check(mealy_state == exp_mealy_st(hist), "R5 mealy_state", mealy_state, exp_mealy_st(hist));
      check(hit_moore == prev_exp, "R2 hit_moore", hit_moore, prev_exp);
      check(hit_moore == prev_mealy, "R7 moore vs delayed mealy", hit_moore, prev_mealy);
      exp_now = din & (hist[1:0] == 2'b10);
      check(hit_mealy == exp_now, "R6 mealy before drive", hit_mealy, exp_now);
      din = b;
      #1;
      hist = {hist[1:0], b};
      exp_now = (hist == 3'b101);
      check(hit_mealy == exp_now, "R6 mealy after drive", hit_mealy, exp_now);
      prev_exp   = exp_now;
      prev_mealy = hit_mealy;
   endtask

   task automatic feed(input string bits);
      for (int i = 0; i < bits.len(); i++) step(bits[i] == "1");
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      din = 1'b1;
      #1;
      check(!hit_mealy && !hit_moore, "R1 flags low in reset", {hit_moore, hit_mealy}, 0);
      repeat (2) @(posedge clk);
      @(negedge clk);
      check(moore_state == 2'b00, "R1 moore_state reset", moore_state, 0);
      check(mealy_state == 2'b00, "R1 mealy_state reset", mealy_state, 0);
      check(!hit_mealy && !hit_moore, "R1 flags low in reset", {hit_moore, hit_mealy}, 0);
      din = 1'b0;
      rst = 1'b0;
      hist = 3'b000;
      prev_exp = 1'b0;
      prev_mealy = 1'b0;
   endtask

   task automatic t_seq_111101();
      int hits = 0;
      t_reset();
      for (int i = 0; i < 6; i++) begin
         step((6'b111101 >> (5 - i)) & 1'b1);
         if (hit_mealy) hits++;
         check(hit_mealy == (i == 5), "R2 mealy on 6th bit only", hit_mealy, i == 5);
      end
      step(1'b0);
      check(hits == 1, "R2 single hit in 111101", hits, 1);
   endtask

   task automatic t_seq_10101();
      t_reset();
      step(1'b1); step(1'b0); step(1'b1);
      check(hit_mealy == 1'b1, "R3 hit on 3rd bit", hit_mealy, 1);
      step(1'b0);
      check(hit_moore == 1'b1, "R3 moore after 3rd bit", hit_moore, 1);
      step(1'b1);
      check(hit_mealy == 1'b1, "R3 hit on 5th bit", hit_mealy, 1);
      step(1'b0);
      check(hit_moore == 1'b1, "R3 moore after 5th bit", hit_moore, 1);
   endtask

   task automatic t_seq_110101100();
      t_reset();
      feed("110101100");
      step(1'b0);
   endtask

   // din toggled while state is 10: the Mealy flag follows within the cycle
   task automatic t_mealy_comb();
      t_reset();
      feed("10");
      @(negedge clk);
      din = 1'b0; #1;
      check(hit_mealy == 1'b0, "R6 din=0 in state 10", hit_mealy, 0);
      din = 1'b1; #1;
      check(hit_mealy == 1'b1, "R6 din=1 in state 10", hit_mealy, 1);
      din = 1'b0; #1;
      check(hit_mealy == 1'b0, "R6 din back to 0", hit_mealy, 0);
      hist = {hist[1:0], 1'b0};
      prev_exp = 1'b0;
      prev_mealy = 1'b0;
      feed("101");
      step(1'b0);
   endtask

   task automatic t_random(input int n);
      t_reset();
      for (int i = 0; i < n; i++) step(1'($urandom_range(0, 1)));
      step(1'b0);
   endtask

   initial begin
      t_seq_111101();
      t_seq_10101();
      t_seq_110101100();
      t_mealy_comb();
      t_random(3000);
      t_random(500);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end
endmodule